// File: doc/BRIEF.md
# Dual-Compare Free-Running Timer

This block is a free-running up-counter with two compare channels. On every cycle where the tick-enable input is high, the counter is compared with both compare registers and may be cleared by a channel A match. It then advances by one, and the overflow flag is raised when the new value is zero. Each event sets a sticky flag in the control/status register.

A one-cycle request pulse carries a vector number. It is raised only for events that occurred on that tick and whose enable bit is set. When several enabled events coincide, a fixed priority decides which vector is reported.

Software reaches the counter, the two compare registers, the control/status register and the enable register through a simple single-cycle register port. Reads are combinational. Writes take effect at the next clock edge.

Top module: `dual_cmp_timer`

## Requirements
- R1: While `tick_en` is high the counter grows by exactly one per clock and wraps from 0xFFFF to 0x0000; while `tick_en` is low it holds its value.
- R2: Register port map: address 0 is the counter, 1 is compare A, 2 is compare B, 3 is control/status, 4 is interrupt enable, and other addresses read 0. A counter write wins over a tick in the same cycle.
- R3: A tick on which the counter equals compare A sets the compare A flag (status bit 0).
- R4: If the clear-on-A bit (status bit 3) is set when compare A matches, the counter is zeroed and that tick's increment still applies, so the counter reads 1 afterwards.
- R5: Compare B is evaluated after any channel A clear, so a channel A clear makes compare B test against 0. A match sets the compare B flag (status bit 1), and channel B never clears the counter.
- R6: A tick whose increment yields 0x0000 sets the overflow flag (status bit 2). An increment that follows a channel A clear never does.
- R7: Flags are sticky. Writing 0 to a flag bit at address 3 clears it, and writing 1 leaves it unchanged.
- R8: `irq_valid` pulses for one clock, in the cycle after a tick, only when an event on that tick has its enable bit set (enable bit 0 for compare A, bit 1 for compare B, bit 2 for overflow). It stays low otherwise, even when flags are already set.
- R9: `irq_vec` is 16 for compare A, 17 for compare B and 18 for overflow. When several enabled events coincide the priority is overflow, then compare B, then compare A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Advance the timer this cycle |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Combinational read data |
| irq_valid | output | 1 | One-cycle request pulse |
| irq_vec | output | 5 | Vector number of the request |

## Verification
The bench builds the block with its default 16-bit counter and 5-bit vector. Because the counter is writable, the bench can load it next to 0xFFFF or next to a compare value, so wrap, clear-on-match and coincident events take only one or two ticks to reach. The coincident cases place a compare value at 0xFFFF or at 0. This exercises the overflow-over-B-over-A priority, and it also shows that compare B sees the value left by a channel A clear.

// File: rtl/frt_pkg.sv
package frt_pkg;

    localparam int unsigned ADDR_W = 3;
    localparam int unsigned VEC_W  = 5;
    localparam int unsigned SRC_N  = 3;

    localparam logic [VEC_W-1:0] VEC_CMPA = VEC_W'(16);
    localparam logic [VEC_W-1:0] VEC_CMPB = VEC_W'(17);
    localparam logic [VEC_W-1:0] VEC_OVF  = VEC_W'(18);

    // bit positions inside the control/status register
    localparam int unsigned ST_CLRA = 3;

    typedef enum logic [ADDR_W-1:0] {
        RA_COUNT = 3'd0,
        RA_CMPA  = 3'd1,
        RA_CMPB  = 3'd2,
        RA_CTRL  = 3'd3,
        RA_IEN   = 3'd4
    } reg_addr_e;

    // one bit per event source; packed order matches status bits 2..0
    typedef struct packed {
        logic ovf;
        logic cmpb;
        logic cmpa;
    } src_t;

    function automatic logic [VEC_W-1:0] pick_vec(input src_t s);
        if (s.ovf)
            return VEC_OVF;
        else if (s.cmpb)
            return VEC_CMPB;
        else
            return VEC_CMPA;
    endfunction

endpackage

// File: rtl/frt_counter.sv
module frt_counter
    import frt_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             wr_cnt,
    input  logic [CNT_W-1:0] wdata,
    input  logic [CNT_W-1:0] cmp_a,
    input  logic [CNT_W-1:0] cmp_b,
    input  logic             clr_on_a,
    output logic [CNT_W-1:0] cnt,
    output src_t             ev
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] after_a;
    logic [CNT_W-1:0] nxt;
    logic             hit_a;
    logic             hit_b;

    always_comb begin
        hit_a   = (cnt_q == cmp_a);
        // channel A acts first; channel B sees its result
        after_a = (hit_a && clr_on_a) ? '0 : cnt_q;
        hit_b   = (after_a == cmp_b);
        nxt     = after_a + CNT_W'(1);
        ev.cmpa = tick && hit_a;
        ev.cmpb = tick && hit_b;
        ev.ovf  = tick && (nxt == '0);
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (wr_cnt)
            cnt_q <= wdata;
        else if (tick)
            cnt_q <= nxt;
    end

    assign cnt = cnt_q;

    a_r1_plain_step: assert property (@(posedge clk) disable iff (rst)
        (tick && !wr_cnt && !(clr_on_a && cnt_q == cmp_a))
            |=> cnt_q == CNT_W'($past(cnt_q) + CNT_W'(1)));

    a_r1_hold: assert property (@(posedge clk) disable iff (rst)
        (!tick && !wr_cnt) |=> $stable(cnt_q));

    a_r4_clear_gives_one: assert property (@(posedge clk) disable iff (rst)
        (tick && !wr_cnt && clr_on_a && cnt_q == cmp_a) |=> cnt_q == CNT_W'(1));

endmodule

// File: rtl/frt_status.sv
module frt_status
    import frt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_ctrl,
    input  logic [SRC_N-1:0] wflags,
    input  logic             wclr,
    input  src_t             ev,
    output src_t             flags,
    output logic             clr_on_a
);

    src_t flags_q;
    logic clr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            clr_q   <= 1'b0;
        end else begin
            // a 0 clears, a 1 keeps; a new event wins over a clear
            flags_q <= (wr_ctrl ? (flags_q & src_t'(wflags)) : flags_q) | ev;
            if (wr_ctrl)
                clr_q <= wclr;
        end
    end

    assign flags    = flags_q;
    assign clr_on_a = clr_q;

    for (genvar i = 0; i < SRC_N; i++) begin : g_chk
        a_r7_clear_only_by_write: assert property (@(posedge clk) disable iff (rst)
            $fell(flags_q[i]) |-> $past(wr_ctrl && !wflags[i]));
        a_r7_event_sets: assert property (@(posedge clk) disable iff (rst)
            ev[i] |=> flags_q[i]);
    end

endmodule

// File: rtl/frt_irq.sv
module frt_irq
    import frt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  src_t             ev,
    input  logic [SRC_N-1:0] ien,
    output logic             irq_valid,
    output logic [VEC_W-1:0] irq_vec
);

    src_t hit;
    logic valid_q;
    logic [VEC_W-1:0] vec_q;

    assign hit = ev & src_t'(ien);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            vec_q   <= '0;
        end else begin
            valid_q <= tick && (hit != '0);
            vec_q   <= pick_vec(hit);
        end
    end

    assign irq_valid = valid_q;
    assign irq_vec   = vec_q;

    a_r8_needs_tick: assert property (@(posedge clk) disable iff (rst)
        valid_q |-> $past(tick));

    a_r9_vec_range: assert property (@(posedge clk) disable iff (rst)
        valid_q |-> (vec_q == VEC_CMPA || vec_q == VEC_CMPB || vec_q == VEC_OVF));

    a_r9_ovf_first: assert property (@(posedge clk) disable iff (rst)
        (ev.ovf && ien[2]) |=> (valid_q && vec_q == VEC_OVF));

endmodule

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer
    import frt_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [CNT_W-1:0]  reg_wdata,
    output logic [CNT_W-1:0]  reg_rdata,
    output logic              irq_valid,
    output logic [VEC_W-1:0]  irq_vec
);

    localparam int unsigned CTRL_W = ST_CLRA + 1;

    logic [CNT_W-1:0] cmp_a_q;
    logic [CNT_W-1:0] cmp_b_q;
    logic [SRC_N-1:0] ien_q;
    logic [CNT_W-1:0] cnt;
    logic             clr_on_a;
    src_t             ev;
    src_t             flags;

    logic wr_cnt, wr_cmpa, wr_cmpb, wr_ctrl, wr_ien;

    always_comb begin
        wr_cnt  = reg_wr && (reg_addr == RA_COUNT);
        wr_cmpa = reg_wr && (reg_addr == RA_CMPA);
        wr_cmpb = reg_wr && (reg_addr == RA_CMPB);
        wr_ctrl = reg_wr && (reg_addr == RA_CTRL);
        wr_ien  = reg_wr && (reg_addr == RA_IEN);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_a_q <= '1;
            cmp_b_q <= '1;
            ien_q   <= '0;
        end else begin
            if (wr_cmpa) cmp_a_q <= reg_wdata;
            if (wr_cmpb) cmp_b_q <= reg_wdata;
            if (wr_ien)  ien_q   <= reg_wdata[SRC_N-1:0];
        end
    end

    frt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick_en),
        .wr_cnt   (wr_cnt),
        .wdata    (reg_wdata),
        .cmp_a    (cmp_a_q),
        .cmp_b    (cmp_b_q),
        .clr_on_a (clr_on_a),
        .cnt      (cnt),
        .ev       (ev)
    );

    frt_status u_st (
        .clk      (clk),
        .rst      (rst),
        .wr_ctrl  (wr_ctrl),
        .wflags   (reg_wdata[SRC_N-1:0]),
        .wclr     (reg_wdata[ST_CLRA]),
        .ev       (ev),
        .flags    (flags),
        .clr_on_a (clr_on_a)
    );

    frt_irq u_irq (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick_en),
        .ev        (ev),
        .ien       (ien_q),
        .irq_valid (irq_valid),
        .irq_vec   (irq_vec)
    );

    always_comb begin
        unique case (reg_addr)
            RA_COUNT: reg_rdata = cnt;
            RA_CMPA:  reg_rdata = cmp_a_q;
            RA_CMPB:  reg_rdata = cmp_b_q;
            RA_CTRL:  reg_rdata = CNT_W'({clr_on_a, flags});
            RA_IEN:   reg_rdata = CNT_W'(ien_q);
            default:  reg_rdata = '0;
        endcase
    end

    a_r2_cnt_write: assert property (@(posedge clk) disable iff (rst)
        wr_cnt |=> cnt == $past(reg_wdata));

    a_r2_ctrl_width: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == RA_CTRL) |-> (reg_rdata >> CTRL_W) == '0);

endmodule

// File: tb/dual_cmp_timer_tb_top.sv
`timescale 1ns/1ps
module dual_cmp_timer_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq_valid;
    logic [4:0]  irq_vec;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    dual_cmp_timer dut_i (
        .clk(clk), .rst(rst), .tick_en(tick_en), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_valid(irq_valid), .irq_vec(irq_vec)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int v);
        reg_addr = a;
        #0.5;
        v = int'(reg_rdata);
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    // park compares away, clear flags, set clear-on-A and enables
    task automatic setup(input logic [15:0] ca, input logic [15:0] cb,
                         input logic clra, input logic [2:0] en, input logic [15:0] c);
        wr(3'd1, ca);
        wr(3'd2, cb);
        wr(3'd3, {12'd0, clra, 3'b000});
        wr(3'd4, {13'd0, en});
        wr(3'd0, c);
    endtask

    task automatic t_reset;
        int v;
        rd(3'd0, v); chk("R1 reset count", v, 0);
        rd(3'd3, v); chk("R7 reset flags", v, 0);
        chk("R8 reset irq", int'(irq_valid), 0);
    endtask

    task automatic t_count;
        int v;
        setup(16'h8000, 16'h8000, 1'b0, 3'b000, 16'h0010);
        ticks(5);
        rd(3'd0, v); chk("R1 five ticks", v, 16'h0015);
        repeat (3) @(negedge clk);
        rd(3'd0, v); chk("R1 hold when idle", v, 16'h0015);
        rd(3'd1, v); chk("R2 cmpA readback", v, 16'h8000);
        rd(3'd6, v); chk("R2 unmapped reads 0", v, 0);
        // write in same cycle as tick: write wins
        @(negedge clk);
        reg_addr = 3'd0; reg_wdata = 16'h0100; reg_wr = 1'b1; tick_en = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; tick_en = 1'b0;
        rd(3'd0, v); chk("R2 write beats tick", v, 16'h0100);
    endtask

    task automatic t_wrap;
        int v;
        setup(16'h1234, 16'h1234, 1'b0, 3'b100, 16'hFFFE);
        ticks(1);
        chk("R8 no irq before wrap", int'(irq_valid), 0);
        ticks(1);
        chk("R8 irq on wrap", int'(irq_valid), 1);
        chk("R9 vector ovf", int'(irq_vec), 18);
        rd(3'd0, v); chk("R1 wrapped to 0", v, 0);
        rd(3'd3, v); chk("R6 ovf flag", v & 7, 3'b100);
        @(negedge clk);
        chk("R8 pulse one cycle", int'(irq_valid), 0);
    endtask

    task automatic t_match_a;
        int v;
        setup(16'h0005, 16'h1234, 1'b1, 3'b001, 16'h0005);
        ticks(1);
        rd(3'd0, v); chk("R4 clear then +1", v, 1);
        rd(3'd3, v); chk("R3 flag A set", v & 7, 3'b001);
        chk("R9 vector A", int'(irq_vec), 16);
        chk("R8 irq A", int'(irq_valid), 1);
        setup(16'h0005, 16'h1234, 1'b0, 3'b000, 16'h0005);
        ticks(1);
        rd(3'd0, v); chk("R4 no clear when off", v, 6);
        rd(3'd3, v); chk("R3 flag A no clear", v & 7, 3'b001);
        chk("R8 disabled no irq", int'(irq_valid), 0);
    endtask

    task automatic t_b_after_clear;
        int v;
        setup(16'h0007, 16'h0000, 1'b1, 3'b011, 16'h0007);
        ticks(1);
        rd(3'd0, v); chk("R5 count after A clear", v, 1);
        rd(3'd3, v); chk("R5 B sees cleared value", v & 7, 3'b011);
        chk("R9 B beats A", int'(irq_vec), 17);
        // B alone never clears
        setup(16'h1234, 16'h0040, 1'b1, 3'b000, 16'h0040);
        ticks(1);
        rd(3'd0, v); chk("R5 B does not clear", v, 16'h0041);
    endtask

    task automatic t_priority;
        int v;
        setup(16'hFFFF, 16'hFFFF, 1'b0, 3'b111, 16'hFFFF);
        ticks(1);
        chk("R9 ovf beats B and A", int'(irq_vec), 18);
        rd(3'd3, v); chk("R6 all three flags", v & 7, 3'b111);
        // clearing at wrap point: no overflow
        setup(16'hFFFF, 16'h1234, 1'b1, 3'b100, 16'hFFFF);
        ticks(1);
        rd(3'd3, v); chk("R6 no ovf after clear", v & 7, 3'b001);
        chk("R8 no ovf irq after clear", int'(irq_valid), 0);
    endtask

    task automatic t_sticky;
        int v;
        setup(16'h0003, 16'h0003, 1'b0, 3'b000, 16'h0003);
        ticks(1);
        rd(3'd3, v); chk("R7 A and B set", v & 7, 3'b011);
        wr(3'd3, 16'h0007);
        rd(3'd3, v); chk("R7 write 1 no effect", v & 7, 3'b011);
        wr(3'd3, 16'h0002);
        rd(3'd3, v); chk("R7 write 0 clears A only", v & 7, 3'b010);
        ticks(4);
        rd(3'd3, v); chk("R7 flag stays set", v & 7, 3'b010);
        wr(3'd3, 16'h0000);
        rd(3'd3, v); chk("R7 all cleared", v & 7, 0);
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_count();
        t_wrap();
        t_match_a();
        t_b_after_clear();
        t_priority();
        t_sticky();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end

endmodule